// File: doc/BRIEF.md
# Command Stream Register Decoder

This block takes a byte-wide command stream and turns it into register state for a display timing engine. Each command starts with a fixed prefix byte and a command code. A register-write command updates a bank of shadow video registers. A special write to the lock index decides whether those writes reach the active registers at once or wait. While the bank is locked, writes are staged in the shadow copies. Unlocking copies every shadow register into the active set in one cycle and raises a commit strobe.

The block also recognises a nine-byte copy command. It reads the payload, including any payload byte that happens to equal the prefix value, and reports the copy as a single-cycle strobe with the source address, destination address and pixel count. No memory access is made. A prefix byte left with no code after it is treated as filler. Bytes that break the framing raise a sticky error flag, and the parser then hunts for the next prefix.

The active registers are presented as one flat vector, register 0 in the least significant byte. The two frame-buffer base addresses and the colour-depth selection are also decoded from them. The default bank holds 64 registers; NUM_REGS must be larger than 0x28.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After synchronous reset, all active registers read zero. The bank is unlocked, the parser waits for a prefix, and commit_pulse, proto_err and copy_valid are low.
- R2: The bytes 0xAF, 0x20, idx, val form a register write. With the bank unlocked, active register idx (idx < NUM_REGS) takes val on the second clock edge after the val byte is accepted. Indices from NUM_REGS to 0xFE have no effect.
- R3: The write of 0x00 to index 0xFF locks the bank. While locked, register writes change only the shadow copies, and active_regs stays the same.
- R4: The write of 0xFF to index 0xFF unlocks the bank and copies all shadow registers into the active set on one edge. commit_pulse is high for exactly the cycle in which the new values first appear. Any other value written to index 0xFF has no effect.
- R5: The bytes 0xAF, 0x6A, then seven payload bytes form a copy command. The payload is: source address as 3 bytes with the most significant byte first, then the pixel count as 1 byte, then the destination address as 3 bytes with the most significant byte first. One cycle after the last byte is accepted, copy_valid is high for one cycle with these fields. Payload bytes, including 0xAF, are never parsed as commands and change no register.
- R6: A 0xAF byte where a command code is expected raises no error and is taken as a fresh prefix, so filler prefixes are tolerated.
- R7: A byte other than 0xAF where a prefix is expected sets proto_err one cycle later. The flag stays set until reset. Bytes are discarded until the next 0xAF.
- R8: An unknown command code (neither 0x20, 0x6A nor 0xAF) sets proto_err one cycle later, and the parser returns to waiting for a prefix.
- R9: base16_addr is {reg 0x20, reg 0x21, reg 0x22}. base8_addr is {reg 0x26, reg 0x27, reg 0x28}. depth_is_16 is high when active register 0x00 is zero.
- R10: in_ready is always high. A cycle with in_valid low advances no parser state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Byte accepted (always high) |
| active_regs | output | NUM_REGS*8 | Active register bank, register i in bits [8i+7:8i] |
| commit_pulse | output | 1 | One-cycle strobe when staged values are committed |
| proto_err | output | 1 | Sticky framing error flag |
| copy_valid | output | 1 | One-cycle strobe for a decoded copy command |
| copy_src | output | 24 | Decoded copy source address |
| copy_count | output | 8 | Decoded copy pixel count |
| copy_dst | output | 24 | Decoded copy destination address |
| base16_addr | output | 24 | 16bpp frame-buffer base address |
| base8_addr | output | 24 | 8bpp frame-buffer base address |
| depth_is_16 | output | 1 | Colour depth selection is 16 bits per pixel |

## Verification
A parser that drops out of step with the framing shows up at the ports within a few bytes. The error flag rises early, or a register write lands on the wrong index or value, or a copy strobe appears with shifted fields or at the wrong cycle. A wrong lock state shows up in the cycle after the next register write: the active bank moves while it should hold, or holds while it should move, and commit_pulse appears on the wrong cycle. The bench compares every output against a behavioural model on every clock. A wrong state therefore shows up within the cycle in which its first effect reaches a port.

// File: rtl/cmd_stream_pkg.sv
package cmd_stream_pkg;
  localparam logic [7:0] BYTE_PREFIX  = 8'hAF;
  localparam logic [7:0] CODE_REGWR   = 8'h20;
  localparam logic [7:0] CODE_COPY    = 8'h6A;
  localparam logic [7:0] GATE_INDEX   = 8'hFF;
  localparam logic [7:0] GATE_CLOSE   = 8'h00;
  localparam logic [7:0] GATE_OPEN    = 8'hFF;
  localparam int         COPY_PAYLOAD = 7;
  localparam int         CNT_W        = $clog2(COPY_PAYLOAD);

  typedef enum logic [2:0] {
    PS_PREFIX,
    PS_CODE,
    PS_INDEX,
    PS_VALUE,
    PS_COPY
  } parse_state_e;

  typedef struct packed {
    logic [23:0] src;
    logic [7:0]  count;
    logic [23:0] dst;
  } copy_desc_t;
endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
  import cmd_stream_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_val,
  output logic       copy_valid,
  output copy_desc_t copy_desc,
  output logic       err
);
  parse_state_e        state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [7:0]          idx_q;
  logic [COPY_PAYLOAD*8-1:0] pay_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PS_PREFIX;
      cnt_q      <= '0;
      idx_q      <= '0;
      pay_q      <= '0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_val     <= '0;
      copy_valid <= 1'b0;
      err        <= 1'b0;
    end else begin
      wr_en      <= 1'b0;
      copy_valid <= 1'b0;
      if (in_valid) begin
        case (state_q)
          PS_PREFIX: begin
            if (in_data == BYTE_PREFIX) state_q <= PS_CODE;
            else err <= 1'b1;
          end
          PS_CODE: begin
            if (in_data == CODE_REGWR) begin
              state_q <= PS_INDEX;
            end else if (in_data == CODE_COPY) begin
              state_q <= PS_COPY;
              cnt_q   <= '0;
            end else if (in_data == BYTE_PREFIX) begin
              state_q <= PS_CODE;
            end else begin
              err     <= 1'b1;
              state_q <= PS_PREFIX;
            end
          end
          PS_INDEX: begin
            idx_q   <= in_data;
            state_q <= PS_VALUE;
          end
          PS_VALUE: begin
            wr_en   <= 1'b1;
            wr_idx  <= idx_q;
            wr_val  <= in_data;
            state_q <= PS_PREFIX;
          end
          PS_COPY: begin
            pay_q <= {pay_q[COPY_PAYLOAD*8-9:0], in_data};
            if (cnt_q == CNT_W'(COPY_PAYLOAD - 1)) begin
              copy_valid <= 1'b1;
              state_q    <= PS_PREFIX;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= PS_PREFIX;
        endcase
      end
    end
  end

  assign copy_desc = copy_desc_t'(pay_q);

  // a copy needs nine bytes, so its strobe can never repeat back to back
  assert_copy_single_R5: assert property (@(posedge clk) disable iff (rst)
    copy_valid |=> !copy_valid);
  // a register write needs four bytes
  assert_write_single_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import cmd_stream_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_val,
  output logic [NUM_REGS*8-1:0] active_flat,
  output logic                  commit_q
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [7:0] shadow_q [NUM_REGS];
  logic [7:0] active_q [NUM_REGS];
  logic       locked_q;
  logic       in_range;

  assign in_range = int'(wr_idx) < NUM_REGS;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      commit_q <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) begin
        shadow_q[i] <= '0;
        active_q[i] <= '0;
      end
    end else begin
      commit_q <= 1'b0;
      if (wr_en) begin
        if (wr_idx == GATE_INDEX) begin
          if (wr_val == GATE_CLOSE) begin
            locked_q <= 1'b1;
          end else if (wr_val == GATE_OPEN) begin
            locked_q <= 1'b0;
            commit_q <= 1'b1;
            for (int i = 0; i < NUM_REGS; i++) active_q[i] <= shadow_q[i];
          end
        end else if (in_range) begin
          shadow_q[wr_idx[IDX_W-1:0]] <= wr_val;
          if (!locked_q) active_q[wr_idx[IDX_W-1:0]] <= wr_val;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign active_flat[g*8 +: 8] = active_q[g];
  end

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> ($stable(active_flat) || commit_q));
  assert_commit_unlocks_R4: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> !locked_q);
  assert_commit_single_R4: assert property (@(posedge clk) disable iff (rst)
    commit_q |=> !commit_q);
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import cmd_stream_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  output logic                  in_ready,
  output logic [NUM_REGS*8-1:0] active_regs,
  output logic                  commit_pulse,
  output logic                  proto_err,
  output logic                  copy_valid,
  output logic [23:0]           copy_src,
  output logic [7:0]            copy_count,
  output logic [23:0]           copy_dst,
  output logic [23:0]           base16_addr,
  output logic [23:0]           base8_addr,
  output logic                  depth_is_16
);
  localparam int REG_DEPTH = 8'h00;
  localparam int REG_B16   = 8'h20;
  localparam int REG_B8    = 8'h26;

  logic       wr_en;
  logic [7:0] wr_idx;
  logic [7:0] wr_val;
  copy_desc_t desc;

  cmd_parser parser_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_val     (wr_val),
    .copy_valid (copy_valid),
    .copy_desc  (desc),
    .err        (proto_err)
  );

  reg_bank #(.NUM_REGS(NUM_REGS)) bank_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_val      (wr_val),
    .active_flat (active_regs),
    .commit_q    (commit_pulse)
  );

  assign in_ready    = 1'b1;
  assign copy_src    = desc.src;
  assign copy_count  = desc.count;
  assign copy_dst    = desc.dst;
  assign base16_addr = {active_regs[REG_B16*8 +: 8], active_regs[(REG_B16+1)*8 +: 8],
                        active_regs[(REG_B16+2)*8 +: 8]};
  assign base8_addr  = {active_regs[REG_B8*8 +: 8], active_regs[(REG_B8+1)*8 +: 8],
                        active_regs[(REG_B8+2)*8 +: 8]};
  assign depth_is_16 = (active_regs[REG_DEPTH*8 +: 8] == 8'h00);
endmodule

// File: tb/cmd_stream_decoder_tb_top.sv
module cmd_stream_decoder_tb_top;
  localparam int N = 64;
  localparam int W = N * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, commit_pulse, proto_err, copy_valid, depth_is_16;
  logic [W-1:0] active_regs;
  logic [23:0] copy_src, copy_dst, base16_addr, base8_addr;
  logic [7:0] copy_count;

  always #10 clk = ~clk;

  cmd_stream_decoder #(.NUM_REGS(N)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .active_regs(active_regs), .commit_pulse(commit_pulse), .proto_err(proto_err),
    .copy_valid(copy_valid), .copy_src(copy_src), .copy_count(copy_count),
    .copy_dst(copy_dst), .base16_addr(base16_addr), .base8_addr(base8_addr),
    .depth_is_16(depth_is_16)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  int m_state;            // 0 prefix, 1 code, 2 index, 3 value, 4 payload
  int m_cnt;
  byte unsigned m_idx;
  byte unsigned m_pay[7];
  byte unsigned m_sh[N];
  byte unsigned m_ac[N];
  bit m_locked, m_err, m_commit, m_copy;
  bit pend_v;
  byte unsigned pend_idx, pend_val;
  logic [23:0] m_src, m_dst;
  logic [7:0] m_count;

  task automatic model_reset();
    m_state = 0; m_cnt = 0; m_idx = 0; m_locked = 0; m_err = 0;
    m_commit = 0; m_copy = 0; pend_v = 0;
    for (int i = 0; i < N; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
  endtask

  function automatic logic [W-1:0] exp_flat();
    logic [W-1:0] f;
    for (int i = 0; i < N; i++) f[i*8 +: 8] = m_ac[i];
    return f;
  endfunction

  // advance the model by one clock edge with the given input
  task automatic model_edge(input bit v, input byte unsigned d);
    m_commit = 0;
    m_copy = 0;
    if (pend_v) begin
      if (pend_idx == 8'hFF) begin
        if (pend_val == 8'h00) m_locked = 1;
        else if (pend_val == 8'hFF) begin
          m_locked = 0;
          m_commit = 1;
          for (int i = 0; i < N; i++) m_ac[i] = m_sh[i];
        end
      end else if (pend_idx < N) begin
        m_sh[pend_idx] = pend_val;
        if (!m_locked) m_ac[pend_idx] = pend_val;
      end
      pend_v = 0;
    end
    if (v) begin
      case (m_state)
        0: if (d == 8'hAF) m_state = 1; else m_err = 1;
        1: begin
          if (d == 8'h20) m_state = 2;
          else if (d == 8'h6A) begin m_state = 4; m_cnt = 0; end
          else if (d == 8'hAF) m_state = 1;
          else begin m_err = 1; m_state = 0; end
        end
        2: begin m_idx = d; m_state = 3; end
        3: begin pend_v = 1; pend_idx = m_idx; pend_val = d; m_state = 0; end
        default: begin
          m_pay[m_cnt] = d;
          m_cnt++;
          if (m_cnt == 7) begin
            m_copy = 1;
            m_src = {m_pay[0], m_pay[1], m_pay[2]};
            m_count = m_pay[3];
            m_dst = {m_pay[4], m_pay[5], m_pay[6]};
            m_state = 0;
          end
        end
      endcase
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%0h expected=%0h", req, what, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [W-1:0] ef;
    ef = exp_flat();
    chk(active_regs === ef, "R2 R3 R4", "active_regs", active_regs, ef);
    chk(commit_pulse === m_commit, "R4", "commit_pulse", W'(commit_pulse), W'(m_commit));
    chk(proto_err === m_err, "R7 R8", "proto_err", W'(proto_err), W'(m_err));
    chk(copy_valid === m_copy, "R5", "copy_valid", W'(copy_valid), W'(m_copy));
    if (m_copy) begin
      chk(copy_src === m_src, "R5", "copy_src", W'(copy_src), W'(m_src));
      chk(copy_count === m_count, "R5", "copy_count", W'(copy_count), W'(m_count));
      chk(copy_dst === m_dst, "R5", "copy_dst", W'(copy_dst), W'(m_dst));
    end
    chk(base16_addr === {m_ac[8'h20], m_ac[8'h21], m_ac[8'h22]}, "R9", "base16_addr",
        W'(base16_addr), W'({m_ac[8'h20], m_ac[8'h21], m_ac[8'h22]}));
    chk(base8_addr === {m_ac[8'h26], m_ac[8'h27], m_ac[8'h28]}, "R9", "base8_addr",
        W'(base8_addr), W'({m_ac[8'h26], m_ac[8'h27], m_ac[8'h28]}));
    chk(depth_is_16 === (m_ac[0] == 0), "R9", "depth_is_16",
        W'(depth_is_16), W'(m_ac[0] == 0));
    chk(in_ready === 1'b1, "R10", "in_ready", W'(in_ready), W'(1));
  endtask

  // one clock: check outputs away from the edge, then drive and advance the model
  task automatic step(input bit v, input byte unsigned d);
    @(negedge clk);
    compare_all();
    in_valid = v;
    in_data = d;
    model_edge(v, d);
  endtask

  task automatic put(input byte unsigned d);
    step(1, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h5A);
  endtask

  task automatic regwr(input byte unsigned idx, input byte unsigned val);
    put(8'hAF); put(8'h20); put(idx); put(val);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
    // R1: reset state seen at the ports
    chk(active_regs === '0, "R1", "reset active_regs", active_regs, '0);
    chk(proto_err === 0 && commit_pulse === 0 && copy_valid === 0, "R1", "reset strobes",
        W'({proto_err, commit_pulse, copy_valid}), '0);
    chk(depth_is_16 === 1, "R1", "reset depth", W'(depth_is_16), W'(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R2: unlocked writes, with idle gaps (R10)
    regwr(8'h05, 8'h3C);
    idle(2);
    put(8'hAF); idle(1); put(8'h20); idle(3); put(8'h06); put(8'h81);
    regwr(8'h80, 8'h11);           // out of range, no effect
    regwr(8'hFE, 8'h22);
    // R9: base addresses and depth
    regwr(8'h20, 8'h12); regwr(8'h21, 8'h34); regwr(8'h22, 8'h56);
    regwr(8'h26, 8'hAB); regwr(8'h27, 8'hCD); regwr(8'h28, 8'hEF);
    regwr(8'h00, 8'h01);
    idle(2);
    regwr(8'h00, 8'h00);
    // R3: lock, staged writes stay hidden
    regwr(8'hFF, 8'h00);
    regwr(8'h05, 8'h99);
    regwr(8'h10, 8'h77);
    regwr(8'h21, 8'hAA);
    regwr(8'hFF, 8'h55);           // R4: no effect on lock state
    regwr(8'h11, 8'h66);
    idle(3);
    // R4: unlock commits everything
    regwr(8'hFF, 8'hFF);
    idle(3);
    regwr(8'hFF, 8'hFF);           // unlock while open
    // R5: copy command with prefix-valued payload bytes
    put(8'hAF); put(8'h6A);
    put(8'h01); put(8'h02); put(8'h03); put(8'h04); put(8'hAF); put(8'h20); put(8'hFF);
    idle(2);
    put(8'hAF); put(8'h6A);
    put(8'hFE); idle(1); put(8'hDC); put(8'hBA); put(8'h01); put(8'h00); put(8'h00); put(8'h20);
    // R6: filler prefixes are tolerated
    put(8'hAF); idle(2);
    put(8'hAF); put(8'hAF); put(8'h20); put(8'h07); put(8'h42);
    idle(2);
    // R7: non-prefix byte, then resync
    put(8'h00); put(8'h20); put(8'h33);
    regwr(8'h08, 8'h5A);
    put(8'h12);
    idle(2);
    // R8: unknown code after a fresh reset
    do_reset();
    regwr(8'h09, 8'h10);
    put(8'hAF); put(8'h99);
    put(8'h20); put(8'h09); put(8'h11);
    regwr(8'h09, 8'h11);
    put(8'hAF); put(8'h6A);
    for (int i = 0; i < 7; i++) put(byte'(8'h30 + i));
    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule